// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave

This block is the bus-facing slave of a small nonvolatile byte memory. It watches an open-drain clock/data pair sampled by the system clock, finds START and STOP conditions and shifts in an addressing byte. Two bits of that byte are compared with two strap pins, so four such slaves can share one bus. Five further bits of the byte supply the upper part of a 13-bit word address, and its last bit picks the direction. A write carries one more address byte and then up to a page of data. The data is collected in a page buffer, and a self-timed write cycle commits it to the internal array once STOP arrives.

A read returns bytes starting at the current address and advances the address after every byte. While a write cycle runs, the slave is deaf to the bus. The array is a plain register file of `2**ARR_AW` bytes, and the word address is reduced modulo that depth. No data stream leaves the block. The bus pair is the only data path, so there is no valid/ready handshake and no back-pressure except what the bus protocol provides. The single `wr_allow` input stands in for any write-protect policy. `WR_CYCLES` must be at least `PAGE_BYTES`.

Top module: `twi_mem_slave`

## Requirements
- R1: The addressing byte is sent MSB first as {selA, selB, A12..A8, dir}. The block acknowledges it only when selA equals the inverse of `dev_sel_hi` and selB equals `dev_sel_lo`.
- R2: After an addressing byte that does not match, the block never drives SDA and acknowledges nothing until the next START.
- R3: The word address is A12..A8 from the addressing byte followed by the eight bits of the address byte that comes next (A7..A0). Data written there reads back from the same 13-bit address.
- R4: In a write, the block acknowledges the addressing byte, the address byte and every data byte by pulling SDA low during the ninth clock. It only changes SDA while SCL is low.
- R5: All data bytes of one write, up to 32, land at consecutive addresses starting at the given address once STOP is seen.
- R6: Data bytes beyond the page wrap: only the low five address bits advance, the upper bits stay fixed, and a later byte overwrites an earlier one at the same page slot.
- R7: A STOP after at least one complete data byte with `wr_allow` high starts a write cycle of `WR_CYCLES` clocks. During that cycle no request is acknowledged. After it, the block answers again.
- R8: A read (dir = 1) sends bytes MSB first from the current address and adds one to the full address after each byte, including across page boundaries.
- R9: When the master answers a read byte with NACK, the block releases SDA and waits for STOP or START.
- R10: With `wr_allow` low at STOP, all bytes are still acknowledged, but the array is left unchanged and no write cycle starts.
- R11: After reset, SDA is released, the current address is 0 and every array byte reads 0.
- R12: A read's addressing byte replaces the upper five address bits with its A12..A8. The low eight bits come from the current address left by the previous access.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock level |
| sda_i | input | 1 | Bus data level |
| sda_oe | output | 1 | When 1, the pad pulls SDA low |
| dev_sel_hi | input | 1 | Strap; first select bit must be its inverse |
| dev_sel_lo | input | 1 | Strap; second select bit must equal it |
| wr_allow | input | 1 | Permits the write cycle at STOP |

## Verification
A bit counter that is off by one shows up within the same byte: the acknowledge lands in the wrong clock, and the master sees a NACK or a corrupted data bit. A wrong address register shows up only when a byte is read back. For that reason every write is followed by a read that spans page edges and wrapped slots. A write timer that ends early or late shows up as an acknowledge that should not be there, or as one that is missing, on the first request after STOP. Protection and strap decoding errors show up on the very next addressing byte.

// File: rtl/twi_mem_pkg.sv
package twi_mem_pkg;
  localparam int HI_W   = 5;
  localparam int ADDR_W = 8 + HI_W;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_DEV,
    ST_ADDR,
    ST_WDATA,
    ST_ACK,
    ST_RDATA,
    ST_RACK,
    ST_IGNORE,
    ST_BUSY
  } slv_state_t;
endpackage

// File: rtl/twi_line_sense.sv
module twi_line_sense (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_lvl,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [1:0] scl_q;
  logic [1:0] sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 2'b11;
      sda_q <= 2'b11;
    end else begin
      scl_q <= {scl_q[0], scl_i};
      sda_q <= {sda_q[0], sda_i};
    end
  end

  assign sda_lvl   = sda_q[0];
  assign scl_rise  = scl_q[0] & ~scl_q[1];
  assign scl_fall  = ~scl_q[0] & scl_q[1];
  assign start_det = &scl_q & sda_q[1] & ~sda_q[0];
  assign stop_det  = &scl_q & ~sda_q[1] & sda_q[0];
endmodule

// File: rtl/twi_page_buf.sv
module twi_page_buf #(
  parameter int PAGE = 32,
  parameter int DW   = 8,
  localparam int IW  = $clog2(PAGE)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          we,
  input  logic [IW-1:0] widx,
  input  logic [DW-1:0] wdata,
  input  logic [IW-1:0] ridx,
  output logic [DW-1:0] rdata,
  output logic          rvalid,
  output logic          any_valid
);
  logic [DW-1:0]   slot [PAGE];
  logic [PAGE-1:0] filled;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      filled <= '0;
      for (int i = 0; i < PAGE; i++) slot[i] <= '0;
    end else if (clr) begin
      filled <= '0;
    end else if (we) begin
      filled[widx] <= 1'b1;
      slot[widx]   <= wdata;
    end
  end

  assign rdata     = slot[ridx];
  assign rvalid    = filled[ridx];
  assign any_valid = |filled;
endmodule

// File: rtl/twi_mem_array.sv
module twi_mem_array #(
  parameter int AW = 11,
  parameter int DW = 8,
  localparam int DEPTH = 1 << AW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] cells [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) cells[i] <= '0;
    end else if (we) begin
      cells[waddr] <= wdata;
    end
  end

  assign rdata = cells[raddr];
endmodule

// File: rtl/twi_mem_slave.sv
module twi_mem_slave
  import twi_mem_pkg::*;
#(
  parameter int ARR_AW     = 11,
  parameter int PAGE_BYTES = 32,
  parameter int WR_CYCLES  = 600,
  localparam int PG_W  = $clog2(PAGE_BYTES),
  localparam int TMR_W = $clog2(WR_CYCLES + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_oe,
  input  logic dev_sel_hi,
  input  logic dev_sel_lo,
  input  logic wr_allow
);
  logic ln_sda, ln_rise, ln_fall, ln_start, ln_stop;

  twi_line_sense u_sense (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .sda_lvl   (ln_sda),
    .scl_rise  (ln_rise),
    .scl_fall  (ln_fall),
    .start_det (ln_start),
    .stop_det  (ln_stop)
  );

  slv_state_t        st, nxt;
  logic [3:0]        bitcnt;
  logic [7:0]        shreg;
  logic [7:0]        txbyte;
  logic [ADDR_W-1:0] addr;
  logic [TMR_W-1:0]  tmr;

  logic              rx_done, sel_ok;
  logic              pb_we, pb_clr, pb_rvalid, pb_any;
  logic [7:0]        pb_rdata;
  logic [PG_W-1:0]   drain_idx;
  logic              draining;
  logic [ADDR_W-1:0] commit_addr;
  logic              arr_we;
  logic [7:0]        arr_rdata;

  assign rx_done     = ln_fall && (bitcnt == 4'd8);
  assign sel_ok      = (shreg[7] == ~dev_sel_hi) && (shreg[6] == dev_sel_lo);
  assign pb_we       = (st == ST_WDATA) && rx_done;
  assign pb_clr      = (st == ST_ADDR) && rx_done;
  assign drain_idx   = tmr[PG_W-1:0];
  assign draining    = (st == ST_BUSY) && (tmr < TMR_W'(PAGE_BYTES));
  assign commit_addr = {addr[ADDR_W-1:PG_W], drain_idx};
  assign arr_we      = draining && pb_rvalid;

  twi_page_buf #(.PAGE(PAGE_BYTES), .DW(8)) u_page (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (pb_clr),
    .we        (pb_we),
    .widx      (addr[PG_W-1:0]),
    .wdata     (shreg),
    .ridx      (drain_idx),
    .rdata     (pb_rdata),
    .rvalid    (pb_rvalid),
    .any_valid (pb_any)
  );

  twi_mem_array #(.AW(ARR_AW), .DW(8)) u_array (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (arr_we),
    .waddr (commit_addr[ARR_AW-1:0]),
    .wdata (pb_rdata),
    .raddr (addr[ARR_AW-1:0]),
    .rdata (arr_rdata)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      nxt    <= ST_IDLE;
      bitcnt <= '0;
      shreg  <= '0;
      txbyte <= '0;
      addr   <= '0;
      tmr    <= '0;
      sda_oe <= 1'b0;
    end else if (st == ST_BUSY) begin
      // deaf to the bus until the self-timed cycle ends
      if (tmr == TMR_W'(WR_CYCLES - 1)) begin
        tmr <= '0;
        st  <= ST_IDLE;
      end else begin
        tmr <= tmr + 1'b1;
      end
    end else if (ln_start) begin
      st     <= ST_DEV;
      bitcnt <= '0;
      sda_oe <= 1'b0;
    end else if (ln_stop) begin
      sda_oe <= 1'b0;
      bitcnt <= '0;
      tmr    <= '0;
      st     <= (st == ST_WDATA && pb_any && wr_allow) ? ST_BUSY : ST_IDLE;
    end else begin
      case (st)
        ST_DEV, ST_ADDR, ST_WDATA: begin
          if (ln_rise && bitcnt != 4'd8) begin
            shreg  <= {shreg[6:0], ln_sda};
            bitcnt <= bitcnt + 1'b1;
          end else if (rx_done) begin
            if (st == ST_DEV) begin
              if (sel_ok) begin
                addr[ADDR_W-1:8] <= shreg[HI_W:1];
                nxt              <= shreg[0] ? ST_RDATA : ST_ADDR;
                sda_oe           <= 1'b1;
                st               <= ST_ACK;
              end else begin
                st <= ST_IGNORE;
              end
            end else if (st == ST_ADDR) begin
              addr[7:0] <= shreg;
              nxt       <= ST_WDATA;
              sda_oe    <= 1'b1;
              st        <= ST_ACK;
            end else begin
              addr[PG_W-1:0] <= addr[PG_W-1:0] + 1'b1;
              nxt            <= ST_WDATA;
              sda_oe         <= 1'b1;
              st             <= ST_ACK;
            end
          end
        end
        ST_ACK: begin
          if (ln_fall) begin
            bitcnt <= '0;
            st     <= nxt;
            if (nxt == ST_RDATA) begin
              txbyte <= arr_rdata;
              sda_oe <= ~arr_rdata[7];
            end else begin
              sda_oe <= 1'b0;
            end
          end
        end
        ST_RDATA: begin
          if (ln_fall) begin
            if (bitcnt == 4'd7) begin
              sda_oe <= 1'b0;
              st     <= ST_RACK;
            end else begin
              txbyte <= {txbyte[6:0], 1'b0};
              sda_oe <= ~txbyte[6];
              bitcnt <= bitcnt + 1'b1;
            end
          end
        end
        ST_RACK: begin
          if (ln_rise) begin
            addr <= addr + 1'b1;
            if (!ln_sda) begin
              nxt <= ST_RDATA;
              st  <= ST_ACK;
            end else begin
              st <= ST_IGNORE;
            end
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/twi_mem_slave_chk.sv
module twi_mem_slave_chk
  import twi_mem_pkg::*;
#(
  parameter int PG_W      = 5,
  parameter int TMR_W     = 10,
  parameter int WR_CYCLES = 600
) (
  input logic              clk,
  input logic              rst_n,
  input logic              scl_i,
  input logic              sda_oe,
  input slv_state_t        st,
  input logic [ADDR_W-1:0] addr,
  input logic [TMR_W-1:0]  tmr,
  input logic              pb_we,
  input logic              ln_rise
);
  AST_SDA_MOVES_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !scl_i); // R4
  AST_IGNORE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    st == ST_IGNORE |-> !sda_oe); // R2
  AST_BUSY_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    st == ST_BUSY |-> !sda_oe); // R7
  AST_TIMER_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    tmr < TMR_W'(WR_CYCLES)); // R7
  AST_PAGE_UPPER_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
    pb_we |=> $stable(addr[ADDR_W-1:PG_W])); // R6
  AST_READ_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_RACK && ln_rise) |=> addr == ADDR_W'($past(addr) + 1'b1)); // R8
endmodule

bind twi_mem_slave twi_mem_slave_chk #(
  .PG_W(PG_W), .TMR_W(TMR_W), .WR_CYCLES(WR_CYCLES)
) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .scl_i  (scl_i),
  .sda_oe (sda_oe),
  .st     (st),
  .addr   (addr),
  .tmr    (tmr),
  .pb_we  (pb_we),
  .ln_rise(ln_rise)
);

// File: tb/test_twi_mem_slave.sv
`timescale 1ns/1ps
module test_twi_mem_slave;
  localparam int WR_CYC = 600;
  localparam int Q      = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic sel_hi = 1'b1, sel_lo = 1'b0, wr_allow = 1'b1;
  logic sda_oe;
  logic bus;
  assign bus = sda_m & ~sda_oe;

  always #2 clk = ~clk;

  twi_mem_slave i_twi_mem_slave (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(bus), .sda_oe(sda_oe),
    .dev_sel_hi(sel_hi), .dev_sel_lo(sel_lo), .wr_allow(wr_allow)
  );

  int checks = 0, errors = 0;
  bit finished = 0;
  logic [7:0] model [0:2047];
  logic [7:0] exp_q[$], act_q[$];
  string tag_q[$];

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic q(); repeat (Q) @(negedge clk); endtask
  task automatic bus_start(); sda_m = 1; q(); scl_m = 1; q(); sda_m = 0; q(); scl_m = 0; q(); endtask
  task automatic bus_stop(); sda_m = 0; q(); scl_m = 1; q(); sda_m = 1; q(); endtask
  task automatic send_bit(input logic b); sda_m = b; q(); scl_m = 1; q(); q(); scl_m = 0; q(); endtask
  task automatic get_bit(output logic b); sda_m = 1; q(); scl_m = 1; q(); b = bus; q(); scl_m = 0; q(); endtask

  task automatic send_byte(input logic [7:0] d, output bit ack);
    logic x;
    for (int i = 7; i >= 0; i--) send_bit(d[i]);
    get_bit(x);
    ack = !x;
  endtask

  task automatic read_byte(output logic [7:0] d, input bit m_ack);
    logic x;
    for (int i = 7; i >= 0; i--) begin get_bit(x); d[i] = x; end
    send_bit(!m_ack);
  endtask

  function automatic logic [7:0] sb(input logic [12:0] a, input logic rw);
    return {~sel_hi, sel_lo, a[12:8], rw};
  endfunction

  task automatic wr_txn(input logic [12:0] a, input logic [7:0] d[$], string tag);
    bit ack;
    logic [12:0] p = a;
    bus_start();
    send_byte(sb(a, 1'b0), ack); chk(ack, {tag, " addressing ack"}, ack, 1);
    send_byte(a[7:0], ack);      chk(ack, {tag, " address ack"}, ack, 1);
    foreach (d[i]) begin
      send_byte(d[i], ack);
      chk(ack, {tag, " data ack"}, ack, 1);
      if (wr_allow) model[p[10:0]] = d[i];
      p = {p[12:5], 5'(p[4:0] + 5'd1)};
    end
    bus_stop();
  endtask

  task automatic rd_txn(input logic [12:0] a, input int n, input bit set_addr, string tag);
    bit ack;
    logic [7:0] d;
    logic [12:0] p = a;
    bus_start();
    if (set_addr) begin
      send_byte(sb(a, 1'b0), ack); chk(ack, {tag, " dummy write ack"}, ack, 1);
      send_byte(a[7:0], ack);      chk(ack, {tag, " dummy address ack"}, ack, 1);
      bus_start();
    end
    send_byte(sb(a, 1'b1), ack); chk(ack, {tag, " read addressing ack"}, ack, 1);
    for (int i = 0; i < n; i++) begin
      exp_q.push_back(model[p[10:0]]);
      tag_q.push_back(tag);
      read_byte(d, i != n - 1);
      act_q.push_back(d);
      p = p + 13'd1;
    end
    q();
    chk(sda_oe == 1'b0, "R9 released after NACK", sda_oe, 0);
    bus_stop();
  endtask

  task automatic wait_cycle(); repeat (WR_CYC + 100) @(negedge clk); endtask

  // scoreboard monitor
  initial begin
    forever begin
      @(negedge clk);
      while (act_q.size() != 0 && exp_q.size() != 0) begin
        logic [7:0] a, e;
        string t;
        a = act_q.pop_front(); e = exp_q.pop_front(); t = tag_q.pop_front();
        chk(a == e, {t, " read data"}, a, e);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    bit ack;
    for (int i = 0; i < 2048; i++) model[i] = 8'h00;
    repeat (5) @(negedge clk);
    chk(sda_oe == 1'b0, "R11 SDA released in reset", sda_oe, 0);
    rst_n = 1;
    repeat (5) @(negedge clk);
    chk(sda_oe == 1'b0, "R11 SDA released after reset", sda_oe, 0);
    rd_txn(13'h000, 2, 1'b0, "R11 current read from reset");

    // R2: non-matching select bits
    bus_start();
    send_byte({1'b1, 1'b0, 5'h02, 1'b0}, ack); chk(!ack, "R2 mismatch NACK", ack, 0);
    send_byte(8'h00, ack);                     chk(!ack, "R2 ignored after mismatch", ack, 0);
    bus_stop();

    // R1, R4, R7: byte write then deafness
    wr_txn(13'h2A5, '{8'h5C}, "R4 byte write");
    bus_start();
    send_byte(sb(13'h000, 1'b0), ack); chk(!ack, "R7 NACK while writing", ack, 0);
    bus_stop();
    wait_cycle();
    wr_txn(13'h462, '{8'h77}, "R7 answers after cycle");
    wait_cycle();

    rd_txn(13'h2A5, 1, 1'b1, "R3 random read");

    // R5 page write
    wr_txn(13'h340, '{8'h11, 8'h22, 8'h33, 8'h44, 8'h55}, "R5 page write");
    wait_cycle();
    rd_txn(13'h340, 6, 1'b1, "R5 sequential readback");

    // R6 wrap beyond page
    begin
      logic [7:0] d[$];
      for (int i = 0; i < 36; i++) d.push_back(8'(8'h80 + i));
      wr_txn(13'h41C, d, "R6 wrap write");
    end
    wait_cycle();
    rd_txn(13'h400, 32, 1'b1, "R6 wrapped page");

    // R8 read across page edge
    wr_txn(13'h35E, '{8'hAA, 8'hBB}, "R8 setup");
    wait_cycle();
    wr_txn(13'h360, '{8'hCC}, "R8 setup");
    wait_cycle();
    rd_txn(13'h35E, 4, 1'b1, "R8 cross-page read");

    // R12: upper bits from read addressing byte, low byte from counter (0x62)
    rd_txn(13'h462, 1, 1'b0, "R12 current read with new upper bits");

    // R10: writes refused
    wr_allow = 0;
    wr_txn(13'h2A5, '{8'hEE}, "R10 refused write");
    bus_start();
    send_byte(sb(13'h000, 1'b0), ack); chk(ack, "R10 no write cycle started", ack, 1);
    bus_stop();
    wr_allow = 1;
    rd_txn(13'h2A5, 1, 1'b1, "R10 array unchanged");

    // R1: other strap setting
    sel_hi = 0; sel_lo = 1;
    bus_start();
    send_byte({1'b0, 1'b1, 5'h03, 1'b1}, ack); chk(!ack, "R1 non-inverted bit rejected", ack, 0);
    bus_stop();
    rd_txn(13'h340, 2, 1'b1, "R1 strap-matched read");

    repeat (20) @(negedge clk);
    if (!finished) begin
      finished = 1;
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule